// File: doc/BRIEF.md
# Interrupt-Capable Pin Controller

This peripheral manages 32 general-purpose pins from a word-aligned 32-bit register bus. Each pin has its own 8-bit configuration word. The word holds an output-drive switch, a driver-buffer switch, an input switch, an interrupt gate and a 3-bit trigger selector. Three shared words sit above the configuration words: the pending-event bits, the synchronised pin levels and the levels that the block drives out.

Every incoming pin passes through a two-stage synchroniser. The synchronised value is compared with its copy from one cycle earlier to find edges. A per-pin event unit evaluates the chosen trigger and latches a pending bit, and software clears that bit by writing a one to it. The OR of all pending bits drives a single registered interrupt line. The pad-facing outputs are a level vector and a drive-enable vector; the pads themselves sit outside this block.

The bus is a plain select/write strobe pair. A write takes effect at the clock edge where it is presented. Read data is combinational and is valid while select is high and write is low.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every configuration word, the drive-level word and the pending word read 0, `pin_oe` is 0 and `irq` is 0.
- R2: The configuration word of pin i is at byte address 4*i. Its bit 0 is output drive, bit 1 input enable, bit 2 driver buffer, bit 3 interrupt gate and bits 7:5 the trigger. On read back, bits 31:8 and bit 4 return 0.
- R3: `pin_oe[i]` is 1 exactly when configuration bits 0 and 2 of pin i are both 1, and it changes only after a bus write.
- R4: The word at 0x84 returns the pin levels two clock edges after they are applied. Writes to it are ignored. Addresses outside the map, or not word-aligned, read 0 and ignore writes.
- R5: The word at 0x88 is read/write, and bit i appears on `pin_out[i]`.
- R6: Trigger 3'b010 sets pending bit i on a 0-to-1 transition of the synchronised pin.
- R7: Trigger 3'b011 sets the pending bit on a 1-to-0 transition.
- R8: Trigger 3'b100 sets the pending bit on either transition.
- R9: Trigger 3'b000 sets the pending bit on every cycle the pin is high, and trigger 3'b001 on every cycle it is low. A clear while the level persists is immediately undone.
- R10: Writing 1 to bit i of 0x80 clears pending bit i. Writing 0 leaves it unchanged. An edge-triggered bit stays set until it is cleared.
- R11: When a set event and a write-1 clear meet the same bit in the same cycle, the bit ends up set.
- R12: A pending bit is never set while the pin's interrupt gate is 0. Events seen while the gate was 0 are not recorded later.
- R13: Trigger codes 3'b101, 3'b110 and 3'b111 never set the pending bit.
- R14: `irq` equals the OR of the pending bits one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Levels driven toward the pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench presents a write-1 clear in the same cycle as a new edge. A design that lets the clear win would lose that event and read 0. It clears a level-triggered bit while the level is still active, which catches a design that fails to re-set the bit on the following cycle. It also raises edges while the gate is closed and then opens the gate, which exposes any design that records events early or back-fills them. Finally, it exercises the unused trigger codes, writes to the read-only and undefined addresses, and samples the input word one cycle too early, which catches a synchroniser that is too shallow.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PINS = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CFG_W    = 8;

    localparam logic [ADDR_W-1:0] STATUS_OFS = 8'h80;
    localparam logic [ADDR_W-1:0] INPUT_OFS  = 8'h84;
    localparam logic [ADDR_W-1:0] OUTPUT_OFS = 8'h88;

    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'b000,
        TRIG_LVL_LO = 3'b001,
        TRIG_RISE   = 3'b010,
        TRIG_FALL   = 3'b011,
        TRIG_BOTH   = 3'b100
    } trig_e;

    typedef struct packed {
        logic [2:0] trig;
        logic       rsvd;
        logic       irq_en;
        logic       buf_en;
        logic       in_en;
        logic       out_en;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c      = w[CFG_W-1:0];
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic trig_hit(input logic [2:0] trig,
                                      input logic cur,
                                      input logic prev);
        logic h;
        case (trig)
            3'(TRIG_LVL_HI): h = cur;
            3'(TRIG_LVL_LO): h = !cur;
            3'(TRIG_RISE):   h = cur && !prev;
            3'(TRIG_FALL):   h = !cur && prev;
            3'(TRIG_BOTH):   h = cur ^ prev;
            default:         h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cur,
    input  logic       prev,
    input  logic [2:0] trig,
    input  logic       irq_en,
    input  logic       clr,
    output logic       pend
);
    logic hit;

    always_comb hit = irq_en && trig_hit(trig, cur, prev);

    // A new event in the same cycle overrides a clear request.
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend && !clr) || hit;
    end

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!pend && !irq_en) |=> !pend);                                  // R12
    AST_BAD_TRIG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pend && trig > 3'd4) |=> !pend);                              // R13
    AST_STICKY_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);                                       // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (irq_en && trig == 3'(TRIG_RISE) && cur && !prev) |=> pend);    // R11
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int IDX_W = $clog2(NPINS);

    pin_cfg_t             cfg_q [NPINS];
    logic [NPINS-1:0]     out_q;
    logic [NPINS-1:0]     pin_sync;
    logic [NPINS-1:0]     pin_prev;
    logic [NPINS-1:0]     status;
    logic [NPINS-1:0]     clr_vec;
    logic                 wr_en;
    logic                 is_ctrl;
    logic [IDX_W-1:0]     ctrl_idx;

    always_comb begin
        wr_en    = bus_sel && bus_write;
        is_ctrl  = (int'(bus_addr[ADDR_W-1:2]) < NPINS) && (bus_addr[1:0] == 2'b00);
        ctrl_idx = bus_addr[IDX_W+1:2];
        clr_vec  = (wr_en && bus_addr == STATUS_OFS) ? bus_wdata[NPINS-1:0] : '0;
    end

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= '0;
            out_q    <= '0;
            irq      <= 1'b0;
        end else begin
            pin_prev <= pin_sync;
            irq      <= |status;
            if (wr_en && bus_addr == OUTPUT_OFS) out_q <= bus_wdata[NPINS-1:0];
        end
    end

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[k] <= '0;
            else if (wr_en && is_ctrl && int'(ctrl_idx) == k)
                cfg_q[k] <= cfg_from_word(bus_wdata);
        end

        assign pin_oe[k] = cfg_q[k].out_en && cfg_q[k].buf_en;

        gpio_irq_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .cur    (pin_sync[k]),
            .prev   (pin_prev[k]),
            .trig   (cfg_q[k].trig),
            .irq_en (cfg_q[k].irq_en),
            .clr    (clr_vec[k]),
            .pend   (status[k])
        );
    end

    assign pin_out = out_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_write) begin
            if (is_ctrl)
                bus_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q[ctrl_idx]};
            else if (bus_addr == STATUS_OFS)
                bus_rdata = DATA_W'(status);
            else if (bus_addr == INPUT_OFS)
                bus_rdata = DATA_W'(pin_sync);
            else if (bus_addr == OUTPUT_OFS)
                bus_rdata = DATA_W'(out_q);
        end
    end

    AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|status)));                              // R14
    AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_oe) |-> $past(bus_sel && bus_write));              // R3
    AST_OUT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out) |-> $past(bus_sel && bus_write && bus_addr == OUTPUT_OFS)); // R5
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    localparam int K_BUS = 0;
    localparam int K_OE  = 1;
    localparam int K_OUT = 2;
    localparam int K_IRQ = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Monitor: pops the expected item of each slot and compares it.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_BUS:   act = bus_rdata;
                    K_OE:    act = pin_oe;
                    K_OUT:   act = pin_out;
                    default: act = {31'b0, irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        it.kind = K_BUS; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_port(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_write = 1'b0;
        end
    endtask

    task automatic do_pins(input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0; pin_in = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_rd(8'h00, 32'h0, "R1 cfg0");
        do_rd(8'h7C, 32'h0, "R1 cfg31");
        do_rd(8'h80, 32'h0, "R1 pending");
        do_rd(8'h88, 32'h0, "R1 outlevel");
        chk_port(K_OE, 32'h0, "R1 pin_oe");
        chk_port(K_IRQ, 32'h0, "R1 irq");

        // R2 configuration words
        do_wr(8'h0C, 32'hFFFF_FFFF);
        do_rd(8'h0C, 32'h0000_00EF, "R2 cfg3 masked");
        do_wr(8'h7C, 32'h0000_004A);
        do_rd(8'h7C, 32'h0000_004A, "R2 cfg31");

        // R3 drive enable needs both bits
        do_wr(8'h14, 32'h1);
        chk_port(K_OE, 32'h0000_0008, "R3 out only");
        do_wr(8'h14, 32'h5);
        chk_port(K_OE, 32'h0000_0028, "R3 out+buf");
        do_wr(8'h14, 32'h4);
        chk_port(K_OE, 32'h0000_0008, "R3 buf only");

        // R5 output level word
        do_wr(8'h88, 32'hA5A5_0F0F);
        do_rd(8'h88, 32'hA5A5_0F0F, "R5 readback");
        chk_port(K_OUT, 32'hA5A5_0F0F, "R5 pin_out");

        // R4 input sampling, read-only, undefined offsets
        do_pins(32'h1234_5678);
        do_rd(8'h84, 32'h0, "R4 one edge");
        do_rd(8'h84, 32'h1234_5678, "R4 two edges");
        do_wr(8'h84, 32'hFFFF_FFFF);
        do_rd(8'h84, 32'h1234_5678, "R4 read-only");
        do_wr(8'h8C, 32'hFFFF_FFFF);
        do_wr(8'hFC, 32'hFFFF_FFFF);
        do_wr(8'h81, 32'hFFFF_FFFF);
        do_rd(8'h8C, 32'h0, "R4 undefined 8C");
        do_rd(8'h81, 32'h0, "R4 unaligned");
        do_rd(8'h88, 32'hA5A5_0F0F, "R4 out unchanged");
        do_rd(8'h80, 32'h0, "R13 trig 111 pin3");
        do_pins(32'h0);
        do_idle(2);
        do_rd(8'h80, 32'h0, "R13 trig 111 fall");

        // R6 rising edge, pin 31
        do_pins(32'h8000_0000);
        do_idle(2);
        do_rd(8'h80, 32'h8000_0000, "R6 rise");
        chk_port(K_IRQ, 32'h1, "R14 irq high");
        do_wr(8'h80, 32'h0);
        do_rd(8'h80, 32'h8000_0000, "R10 write 0");
        do_wr(8'h80, 32'h8000_0000);
        do_rd(8'h80, 32'h0, "R10 write 1");
        chk_port(K_IRQ, 32'h0, "R14 irq low");
        do_idle(2);
        do_rd(8'h80, 32'h0, "R6 no re-set");

        // R7 falling edge, pin 8
        do_wr(8'h20, 32'h68);
        do_pins(32'h8000_0100);
        do_idle(2);
        do_rd(8'h80, 32'h0, "R7 rise ignored");
        do_pins(32'h8000_0000);
        do_idle(2);
        do_rd(8'h80, 32'h0000_0100, "R7 fall");
        do_wr(8'h80, 32'h0000_0100);
        do_rd(8'h80, 32'h0, "R10 clear pin8");

        // R8 both edges, pin 9
        do_wr(8'h24, 32'h88);
        do_pins(32'h8000_0200);
        do_idle(2);
        do_rd(8'h80, 32'h0000_0200, "R8 rise");
        do_wr(8'h80, 32'h0000_0200);
        do_rd(8'h80, 32'h0, "R8 cleared");
        do_pins(32'h8000_0000);
        do_idle(2);
        do_rd(8'h80, 32'h0000_0200, "R8 fall");
        do_wr(8'h80, 32'h0000_0200);
        do_rd(8'h80, 32'h0, "R8 cleared again");

        // R9 level high, pin 10
        do_wr(8'h28, 32'h08);
        do_pins(32'h8000_0400);
        do_idle(2);
        do_rd(8'h80, 32'h0000_0400, "R9 level high");
        do_wr(8'h80, 32'h0000_0400);
        do_rd(8'h80, 32'h0000_0400, "R9 re-set after clear");
        do_pins(32'h8000_0000);
        do_idle(2);
        do_wr(8'h80, 32'h0000_0400);
        do_rd(8'h80, 32'h0, "R9 high released");

        // R9 level low, pin 11
        do_wr(8'h2C, 32'h28);
        do_idle(1);
        do_rd(8'h80, 32'h0000_0800, "R9 level low");
        do_pins(32'h8000_0800);
        do_idle(2);
        do_wr(8'h80, 32'h0000_0800);
        do_rd(8'h80, 32'h0, "R9 low released");

        // R11 set beats clear, pin 12
        do_wr(8'h30, 32'h48);
        do_pins(32'h8000_1800);
        do_idle(1);
        do_wr(8'h80, 32'h0000_1000);
        do_rd(8'h80, 32'h0000_1000, "R11 set wins");
        do_wr(8'h80, 32'h0000_1000);
        do_rd(8'h80, 32'h0, "R11 later clear");

        // R12 gate closed, pin 13 rising
        do_wr(8'h34, 32'h40);
        do_pins(32'h8000_3800);
        do_idle(3);
        do_rd(8'h80, 32'h0, "R12 edge gated");
        do_wr(8'h34, 32'h48);
        do_idle(1);
        do_rd(8'h80, 32'h0, "R12 no back-fill");

        // R13 trigger 101, pin 15
        do_wr(8'h3C, 32'hA8);
        do_pins(32'h8000_B800);
        do_idle(3);
        do_rd(8'h80, 32'h0, "R13 trig 101 rise");
        do_pins(32'h8000_3800);
        do_idle(3);
        do_rd(8'h80, 32'h0, "R13 trig 101 fall");

        // R12 level high with gate closed then opened, pin 14
        do_wr(8'h38, 32'h00);
        do_pins(32'h8000_7800);
        do_idle(3);
        do_rd(8'h80, 32'h0, "R12 level gated");
        do_wr(8'h38, 32'h08);
        do_idle(1);
        do_rd(8'h80, 32'h0000_4000, "R12 gate opened");
        chk_port(K_IRQ, 32'h1, "R14 irq from pin14");

        do_idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule